// File: doc/BRIEF.md
# Selectable Performance Counter Unit

This block is the event-counting unit of one hardware thread. It holds one 64-bit control word and four 64-bit counter words. Each counter word is a pair of independent 32-bit counters: an upper one in bits 63:32 and a lower one in bits 31:0. Every one of the eight counters picks one strobe out of a 64-bit event vector. It counts on any cycle where that strobe is high and the thread's current privilege mode is enabled for tracing. Chip-wide strobes, such as a cycle tick, are wired into the event vector of every thread's copy of this unit, so they advance the counters of all threads.

Software reaches the unit through two 64-bit registers. The control register carries the mode enables, a privilege lock, the counter-select field, the event selects and a field of sticky wrap flags. The counter register shows the counter pair that the select field names. Two write-only override bits in a control write keep the stored event selects and wrap flags from being overwritten. This lets software change the select field or the enables without disturbing them.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset every counter and every stored control field is zero, and the control word reads back 0x0000_0000_00C0_0000: bits 24:22 hold the read-only value NUM_PAIRS-1, which is 3.
- R2: An accepted control write stores the lock bit 0, the supervisor-trace enable bit 1, the user-trace enable bit 2 and the select field 20:18, and reads them back at those positions. Bits 3, 10, 17, 21, 25:27 and 63:48 always read zero; bits 3 and 26 are not stored.
- R3: An accepted control write with bit 3 set leaves every stored event select unchanged.
- R4: An accepted control write with bit 26 set leaves the wrap flags unchanged. With bit 26 clear, bits 39:32 of the written data replace the wrap flags.
- R5: Each counter adds one on a cycle where its selected event strobe is high and either user_mode_i=1 with the user-trace enable set, or user_mode_i=0 with the supervisor-trace enable set. Otherwise it holds.
- R6: Event selects are stored per counter pair: the upper select in bits 16:11 and the lower select in bits 9:4. A control write with bit 3 clear stores them into the pair named by the written select field. The control word shows the selects of the currently selected pair, and shows zero when the select field is 4 or above.
- R7: cnt_rdata_o returns {upper, lower} of the pair named by the select field. A counter write loads both halves of that pair. Select values 4 to 7 read zero and ignore counter writes.
- R8: A counter that wraps from 0xFFFF_FFFF to 0 sets wrap flag 2*p (lower) or 2*p+1 (upper) of pair p, visible in control bits 32+flag at the same edge as the zero. The flag stays set until a control write clears it. A wrap in the same cycle as a clearing write leaves the flag set. Flag bits 47:40 read zero.
- R9: While the lock bit is set, a control write with user_mode_i=1 changes nothing, and access_err_o is high for exactly the following cycle. access_err_o is low at every other time.
- R10: A counter write in the same cycle as an increment of that pair loads the written value and sets no wrap flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| user_mode_i | input | 1 | 1 = thread runs in user mode, 0 = supervisor |
| events_i | input | 64 | Event strobes, one per event number |
| ctl_wr_i | input | 1 | Write wdata_i into the control register |
| cnt_wr_i | input | 1 | Write wdata_i into the selected counter pair |
| wdata_i | input | 64 | Write data for either register |
| ctl_rdata_o | output | 64 | Control register read value |
| cnt_rdata_o | output | 64 | Selected counter pair read value |
| access_err_o | output | 1 | One-cycle pulse after a rejected user-mode control write |

## Verification
The bench aims at wrap-flag handling. A counter is preloaded with 0xFFFF_FFFF, and the test shows that the flag appears at the right bit, survives a write with the flag override set, and clears only on a write with that override clear. A design that swapped the upper and lower flag bits, or let an overridden write clear flags, would show the wrong control word. The bench also drives a counter write and an event together, where a design with the wrong priority would read back the written value plus one. It selects pair 5 to show that an out-of-range select reads zero and does not alias onto a real pair. It locks the control register and writes it from user mode, where a design that ignored the mode would change the enables and raise no error pulse.

// File: rtl/pmu_pkg.sv
// Package: field positions of the control word and shared types for the
// performance counter unit. Assumes a fixed 64-bit register layout.
package pmu_pkg;
    localparam int WORD_W     = 64;
    localparam int CNT_W      = 32;
    localparam int EVT_W      = 64;
    localparam int EVS_W      = 6;
    localparam int SEL_W      = 3;
    localparam int FLAG_LSB   = 32;
    localparam int FLAG_W     = 16;
    localparam int FLGRO_BIT  = 26;
    localparam int NUM_LSB    = 22;
    localparam int SEL_LSB    = 18;
    localparam int HI_LSB     = 11;
    localparam int LO_LSB     = 4;
    localparam int SELRO_BIT  = 3;
    localparam int UTR_BIT    = 2;
    localparam int STR_BIT    = 1;
    localparam int LOCK_BIT   = 0;

    // event selects of one counter pair
    typedef struct packed {
        logic [EVS_W-1:0] hi;
        logic [EVS_W-1:0] lo;
    } evsel_t;
endpackage

// File: rtl/pmu_counter.sv
// Module: one 32-bit event counter. A write has priority over an increment.
// wrap_o is a combinational pulse in the cycle an increment rolls over.
module pmu_counter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] count_o,
    output logic             wrap_o
);
    logic [WIDTH-1:0] cnt_q;

    // rollover only when an increment is not overridden by a write
    always_comb wrap_o = inc_i && !wr_i && (&cnt_q);

    // count register: write first, then increment
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (wr_i)  cnt_q <= wdata_i;
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/pmu_ctrl.sv
// Module: control register of the performance counter unit. Holds enables,
// lock, select, per-pair event selects and sticky wrap flags. Assumes
// NUM_PAIRS is 1..8 so that the flags fit the 16-bit field.
module pmu_ctrl
    import pmu_pkg::*;
#(
    parameter int NUM_PAIRS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     user_mode_i,
    input  logic                     ctl_wr_i,
    input  logic [WORD_W-1:0]        wdata_i,
    input  logic [2*NUM_PAIRS-1:0]   wrap_i,
    output logic [SEL_W-1:0]         sel_o,
    output logic                     utr_o,
    output logic                     str_o,
    output evsel_t [NUM_PAIRS-1:0]   evsel_o,
    output logic [WORD_W-1:0]        ctl_rdata_o,
    output logic                     access_err_o
);
    localparam int FLAGS = 2 * NUM_PAIRS;
    localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_PAIRS - 1);

    logic                  lock_q, utr_q, str_q, err_q;
    logic [SEL_W-1:0]      sel_q;
    logic [FLAGS-1:0]      flag_q;
    evsel_t [NUM_PAIRS-1:0] evsel_q;
    logic                  blocked, accept;
    logic [SEL_W-1:0]      wsel;
    logic [FLAG_W-1:0]     flag_field;
    evsel_t                shown;

    // write decode: a locked register rejects user-mode writes
    always_comb begin
        blocked = ctl_wr_i && lock_q && user_mode_i;
        accept  = ctl_wr_i && !blocked;
        wsel    = wdata_i[SEL_LSB +: SEL_W];
    end

    // enables, lock, select and the error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0; utr_q <= 1'b0; str_q <= 1'b0;
            sel_q  <= '0;   err_q <= 1'b0;
        end else begin
            err_q <= blocked;
            if (accept) begin
                lock_q <= wdata_i[LOCK_BIT];
                utr_q  <= wdata_i[UTR_BIT];
                str_q  <= wdata_i[STR_BIT];
                sel_q  <= wsel;
            end
        end
    end

    // per-pair event selects, guarded by the select override bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evsel_q <= '0;
        end else if (accept && !wdata_i[SELRO_BIT] && wsel <= LAST) begin
            for (int p = 0; p < NUM_PAIRS; p++)
                if (wsel == SEL_W'(p)) begin
                    evsel_q[p].hi <= wdata_i[HI_LSB +: EVS_W];
                    evsel_q[p].lo <= wdata_i[LO_LSB +: EVS_W];
                end
        end
    end

    // sticky wrap flags: hardware sets win over a clearing write
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else if (accept && !wdata_i[FLGRO_BIT])
            flag_q <= wdata_i[FLAG_LSB +: FLAGS] | wrap_i;
        else
            flag_q <= flag_q | wrap_i;
    end

    // read-back assembly of the control word
    always_comb begin
        shown = '0;
        for (int p = 0; p < NUM_PAIRS; p++)
            if (sel_q == SEL_W'(p)) shown = evsel_q[p];
        flag_field        = '0;
        flag_field[FLAGS-1:0] = flag_q;
        ctl_rdata_o       = '0;
        ctl_rdata_o[FLAG_LSB +: FLAG_W] = flag_field;
        ctl_rdata_o[NUM_LSB +: SEL_W]   = LAST;
        ctl_rdata_o[SEL_LSB +: SEL_W]   = sel_q;
        ctl_rdata_o[HI_LSB +: EVS_W]    = shown.hi;
        ctl_rdata_o[LO_LSB +: EVS_W]    = shown.lo;
        ctl_rdata_o[UTR_BIT]            = utr_q;
        ctl_rdata_o[STR_BIT]            = str_q;
        ctl_rdata_o[LOCK_BIT]           = lock_q;
    end

    assign sel_o        = sel_q;
    assign utr_o        = utr_q;
    assign str_o        = str_q;
    assign evsel_o      = evsel_q;
    assign access_err_o = err_q;
endmodule

// File: rtl/perf_mon_unit.sv
// Module: per-thread performance counter unit. Routes selected event strobes
// to eight 32-bit counters in four pairs, gated by the mode enables, and
// exposes one pair through the counter port chosen by the select field.
module perf_mon_unit
    import pmu_pkg::*;
#(
    parameter int NUM_PAIRS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              user_mode_i,
    input  logic [EVT_W-1:0]  events_i,
    input  logic              ctl_wr_i,
    input  logic              cnt_wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] ctl_rdata_o,
    output logic [WORD_W-1:0] cnt_rdata_o,
    output logic              access_err_o
);
    logic [SEL_W-1:0]        sel;
    logic                    utr, str, mode_en;
    evsel_t [NUM_PAIRS-1:0]  evsel;
    logic [2*NUM_PAIRS-1:0]  wrap;
    logic [CNT_W-1:0]        cnt [2*NUM_PAIRS];

    pmu_ctrl #(.NUM_PAIRS(NUM_PAIRS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .user_mode_i(user_mode_i),
        .ctl_wr_i(ctl_wr_i), .wdata_i(wdata_i), .wrap_i(wrap),
        .sel_o(sel), .utr_o(utr), .str_o(str), .evsel_o(evsel),
        .ctl_rdata_o(ctl_rdata_o), .access_err_o(access_err_o)
    );

    // mode filter: the current privilege mode must have tracing enabled
    always_comb mode_en = user_mode_i ? utr : str;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic pair_wr;
        // counter writes go only to the selected pair
        always_comb pair_wr = cnt_wr_i && (sel == SEL_W'(p));

        pmu_counter #(.WIDTH(CNT_W)) u_lo (
            .clk(clk), .rst_n(rst_n),
            .inc_i(mode_en && events_i[evsel[p].lo]),
            .wr_i(pair_wr), .wdata_i(wdata_i[CNT_W-1:0]),
            .count_o(cnt[2*p]), .wrap_o(wrap[2*p])
        );
        pmu_counter #(.WIDTH(CNT_W)) u_hi (
            .clk(clk), .rst_n(rst_n),
            .inc_i(mode_en && events_i[evsel[p].hi]),
            .wr_i(pair_wr), .wdata_i(wdata_i[WORD_W-1:CNT_W]),
            .count_o(cnt[2*p+1]), .wrap_o(wrap[2*p+1])
        );
    end

    // counter port: selected pair, zero for an unimplemented select
    always_comb begin
        cnt_rdata_o = '0;
        for (int p = 0; p < NUM_PAIRS; p++)
            if (sel == SEL_W'(p)) cnt_rdata_o = {cnt[2*p+1], cnt[2*p]};
    end
endmodule

// File: rtl/pmu_checker.sv
// Checker: port-level properties of the performance counter unit, bound to
// every instance of the top module.
module pmu_checker #(
    parameter int NUM_PAIRS = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        user_mode_i,
    input logic        ctl_wr_i,
    input logic        cnt_wr_i,
    input logic [63:0] wdata_i,
    input logic [63:0] ctl_rdata_o,
    input logic [63:0] cnt_rdata_o,
    input logic        access_err_o
);
    logic rejected, accepted;
    always_comb begin
        rejected = ctl_wr_i && user_mode_i && ctl_rdata_o[0];
        accepted = ctl_wr_i && !rejected;
    end

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        access_err_o == $past(rejected));

    assert_locked_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |=> $stable(ctl_rdata_o[31:0]));

    assert_sel_override_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && wdata_i[3] && wdata_i[20:18] == ctl_rdata_o[20:18])
        |=> $stable(ctl_rdata_o[16:4]));

    assert_flag_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && wdata_i[26])
        |=> ((ctl_rdata_o[47:32] & $past(ctl_rdata_o[47:32])) == $past(ctl_rdata_o[47:32])));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr_i
        |=> ((ctl_rdata_o[47:32] & $past(ctl_rdata_o[47:32])) == $past(ctl_rdata_o[47:32])));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr_i && !ctl_wr_i && ctl_rdata_o[20:18] < 3'(NUM_PAIRS))
        |=> cnt_rdata_o == $past(wdata_i));
endmodule

bind perf_mon_unit pmu_checker #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
    .clk(clk), .rst_n(rst_n), .user_mode_i(user_mode_i),
    .ctl_wr_i(ctl_wr_i), .cnt_wr_i(cnt_wr_i), .wdata_i(wdata_i),
    .ctl_rdata_o(ctl_rdata_o), .cnt_rdata_o(cnt_rdata_o),
    .access_err_o(access_err_o)
);

// File: tb/perf_mon_unit_tb.sv
// Bench: directed corner cases followed by seeded random traffic, checked
// against a register-level model built from the requirements.
module perf_mon_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        user_mode_i = 1'b0;
    logic [63:0] events_i = '0;
    logic        ctl_wr_i = 1'b0;
    logic        cnt_wr_i = 1'b0;
    logic [63:0] wdata_i = '0;
    logic [63:0] ctl_rdata_o, cnt_rdata_o;
    logic        access_err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    perf_mon_unit u_dut (.*);

    // model state
    logic        m_lock, m_utr, m_str, m_err;
    logic [2:0]  m_sel;
    logic [7:0]  m_flag;
    logic [5:0]  m_evt [4][2];
    logic [31:0] m_cnt [4][2];

    function automatic logic [63:0] exp_ctl();
        logic [63:0] v = '0;
        v[39:32] = m_flag;
        v[24:22] = 3'd3;
        v[20:18] = m_sel;
        if (m_sel < 3'd4) begin
            v[16:11] = m_evt[m_sel[1:0]][1];
            v[9:4]   = m_evt[m_sel[1:0]][0];
        end
        v[2] = m_utr; v[1] = m_str; v[0] = m_lock;
        return v;
    endfunction

    function automatic logic [63:0] exp_cnt();
        if (m_sel >= 3'd4) return '0;
        return {m_cnt[m_sel[1:0]][1], m_cnt[m_sel[1:0]][0]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " control word"}, ctl_rdata_o, exp_ctl());
        chk({tag, " counter port"}, cnt_rdata_o, exp_cnt());
        chk({tag, " access error"}, {63'd0, access_err_o}, {63'd0, m_err});
    endtask

    task automatic model_reset();
        m_lock = 0; m_utr = 0; m_str = 0; m_err = 0; m_sel = '0; m_flag = '0;
        for (int k = 0; k < 4; k++)
            for (int h = 0; h < 2; h++) begin
                m_evt[k][h] = '0; m_cnt[k][h] = '0;
            end
    endtask

    // one clock: drive, advance the model from the pre-edge state, compare
    task automatic step(input logic cw, input logic nw, input logic [63:0] wd,
                        input logic [63:0] ev, input logic um, input string tag);
        logic en, acc;
        logic [7:0] wraps;
        ctl_wr_i = cw; cnt_wr_i = nw; wdata_i = wd; events_i = ev; user_mode_i = um;
        @(posedge clk);
        #1;
        en    = um ? m_utr : m_str;
        acc   = cw && !(m_lock && um);
        m_err = cw && m_lock && um;
        wraps = '0;
        for (int k = 0; k < 4; k++)
            for (int h = 0; h < 2; h++) begin
                if (nw && m_sel == 3'(k))
                    m_cnt[k][h] = h ? wd[63:32] : wd[31:0];
                else if (en && ev[m_evt[k][h]]) begin
                    if (m_cnt[k][h] == 32'hFFFF_FFFF) wraps[2*k+h] = 1'b1;
                    m_cnt[k][h] = m_cnt[k][h] + 1;
                end
            end
        m_flag = ((acc && !wd[26]) ? wd[39:32] : m_flag) | wraps;
        if (acc) begin
            if (!wd[3] && wd[20:18] < 3'd4) begin
                m_evt[wd[19:18]][1] = wd[16:11];
                m_evt[wd[19:18]][0] = wd[9:4];
            end
            m_lock = wd[0]; m_str = wd[1]; m_utr = wd[2]; m_sel = wd[20:18];
        end
        ctl_wr_i = 0; cnt_wr_i = 0;
        check_all(tag);
    endtask

    function automatic logic [63:0] cw_word(input logic [2:0] sel, input logic [5:0] hi,
                                            input logic [5:0] lo, input logic selro,
                                            input logic flro, input logic [7:0] flags,
                                            input logic ut, input logic st, input logic lk);
        logic [63:0] v = '0;
        v[39:32] = flags; v[26] = flro; v[20:18] = sel; v[16:11] = hi; v[9:4] = lo;
        v[3] = selro; v[2] = ut; v[1] = st; v[0] = lk;
        return v;
    endfunction

    initial begin
        int seed;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_all("R1 reset");

        step(1, 0, cw_word(3'd1, 6'd9, 6'd5, 0, 0, 8'h00, 1, 1, 0), '0, 0, "R2 R6 control write");
        step(1, 0, cw_word(3'd1, 6'd20, 6'd21, 1, 0, 8'h00, 1, 1, 0), '0, 0, "R3 select override");
        step(0, 1, 64'h0000_0010_FFFF_FFFE, '0, 0, "R7 counter load");
        step(0, 0, '0, 64'h20, 0, "R5 supervisor count");
        step(0, 0, '0, 64'h220, 0, "R8 lower wrap flag");
        step(1, 0, cw_word(3'd1, 6'd0, 6'd0, 1, 0, 8'h04, 0, 1, 0), '0, 0, "R2 enables");
        step(0, 0, '0, 64'h220, 1, "R5 user mode gated");
        step(1, 0, cw_word(3'd1, 6'd0, 6'd0, 1, 1, 8'h00, 0, 1, 0), '0, 0, "R4 flag override");
        step(1, 0, cw_word(3'd1, 6'd0, 6'd0, 1, 0, 8'h00, 0, 1, 0), '0, 0, "R4 flag clear");
        step(0, 1, 64'hFFFF_FFFF_0000_0007, '0, 0, "R7 load upper max");
        step(1, 0, cw_word(3'd1, 6'd0, 6'd0, 1, 0, 8'h00, 0, 1, 0), 64'h200, 0, "R8 wrap beats clear");
        step(0, 1, 64'h1234_5678_9ABC_DEF0, 64'h220, 0, "R10 write beats increment");
        step(1, 0, cw_word(3'd5, 6'd0, 6'd0, 1, 0, 8'h08, 0, 1, 0), '0, 0, "R7 select 5");
        step(0, 1, 64'hDEAD_BEEF_0000_0001, '0, 0, "R7 select 5 write ignored");
        step(1, 0, cw_word(3'd1, 6'd0, 6'd0, 1, 1, 8'h00, 0, 1, 0), '0, 0, "R7 back to pair 1");
        step(1, 0, cw_word(3'd1, 6'd0, 6'd0, 1, 1, 8'h00, 1, 1, 1), '0, 0, "R9 lock set");
        step(1, 0, cw_word(3'd2, 6'd1, 6'd1, 0, 0, 8'h00, 0, 0, 0), '0, 1, "R9 user write rejected");
        step(0, 0, '0, '0, 1, "R9 error pulse ends");
        step(1, 0, cw_word(3'd1, 6'd0, 6'd0, 1, 1, 8'h00, 1, 1, 0), '0, 0, "R9 supervisor unlock");

        seed = 1234;
        void'($urandom(seed));
        for (int i = 0; i < 4000; i++) begin
            logic cw, nw, um;
            logic [63:0] wd, ev;
            cw = ($urandom % 12) == 0;
            nw = !cw && ($urandom % 10) == 0;
            um = $urandom % 2;
            ev = {$urandom, $urandom};
            wd = {$urandom, $urandom};
            if (cw) begin
                wd[20] = ($urandom % 6) == 0;
                wd[0]  = ($urandom % 4) == 0;
            end
            if (nw) wd = {32'hFFFF_FFF0 | ($urandom % 16), 32'hFFFF_FFF0 | ($urandom % 16)};
            step(cw, nw, wd, ev, um, "random R5 R6 R7 R8");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule